// File: doc/BRIEF.md
# Multi-Lane Serial Flash Host Controller

This block is a register-programmed host for serial flash devices. Firmware configures the clock mode, the lane width and the serial clock divisor. It then writes a word to one of four transmit addresses, and the address it picks sets how many bytes (one to four) the block shifts out. The bytes leave least-significant byte first, most-significant bit first within each byte, on one, two, four or eight data lanes. On every serial clock the block also samples the same number of bits back. It packs the received bytes into a receive register so that firmware recovers them by shifting right by 8*(4-n). The chip-select can be held by firmware across several writes, so that opcode, address, dummy and data phases form one bus transaction. When manual control is off, the block raises chip-select on its own around each word.

Top module: `spi_lane_host`

## Requirements
- R1: After reset the status word (offset 0x04) reads 0xB. Bit 0 is TX-empty, bit 1 is TX-not-full, bit 2 is RX-not-empty and bit 3 is RX-not-full. After reset cs_n is 1, sclk is 0 and every lane output is 0.
- R2: While bit 0 of the enable word (offset 0x10) is 0, a write to a transmit address starts nothing: no serial clock edge appears and the status stays 0xB.
- R3: A write to offset 0x14+4*k sends k bytes, where k=0 means four bytes. The transfer produces exactly 8*n/W sampling clock edges, where W is the lane count.
- R4: Byte j of a transfer is bits 8j+7:8j of the write word. Within a byte, bits go out MSB first. On each clock, lane i carries bit (7-i) of the current W-bit slice, counted from the top of the remaining bits. Single-lane mode uses lane 0 only. Lanes at or above W drive 1.
- R5: The j-th received byte lands at bits 8*(4-n+j)+7:8*(4-n+j) of the receive word (offset 0x24), and all lower bytes are 0. In single-lane mode each bit is sampled from lane_in[1]. In wider modes lane i supplies bit (7-i) of the slice, mirroring R4.
- R6: While a word is shifting, status bits 0 and 1 read 0. When the last bit is done, the status reads 0x7. A read of the receive word then returns the status to 0xB.
- R7: A transmit write made while TX-empty is 0 is dropped. It does not alter the data on the lanes, the received word or the edge count.
- R8: In the config word (offset 0x00), bit 1 gives chip-select to firmware and bit 0 then drives it (cs_n = not bit 0). In this mode cs_n stays low across back-to-back transfers. With bit 1 clear, cs_n is low exactly while a word is shifting.
- R9: Config bit 19 sets the idle level of sclk, and sclk sits at that level whenever cs_n is high. With config bit 20 clear, data is sampled on the first clock edge of each slot. With bit 20 set, data is sampled on the second edge.
- R10: The low 8 bits of the divisor word (offset 0x28) hold D, and one serial clock period lasts 2*(D+1) system clock cycles.
- R11: When no word is shifting, all eight lane outputs equal config bit 16. During a read transfer every lane drives 1.
- R12: In the control word (offset 0x30), bits 7:6 select the lane count (0 for 1 lane, 1 for 2, 2 for 4, 3 for 8), and bit 23 marks a read transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on receive word) |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip-select, active low |
| lane_out | output | 8 | Data driven onto the lanes |
| lane_in | input | 8 | Data sampled from the lanes |

## Verification
The bench loops the lane outputs back to the inputs, with lane 0 routed to lane 1 in single-lane mode, and can optionally invert them. This catches a receiver that samples the wrong lane, or that packs bytes at the wrong end or in reverse order, because the received word would then differ from the shifted word. A scoreboard predicts the lane value at every sampling edge. A swapped lane order, a reversed byte order, a wrong byte count from the transmit address or a wrong phase would all show up as a mismatch or as an extra or missing edge. Further targets are a write made while busy, which a faulty design would accept and use to corrupt the transfer, and chip-select releasing between back-to-back manual transfers. The divisor and the idle levels of sclk and the lanes are also checked, since an off-by-one error or a wrong polarity in either would be visible at the pins.

// File: rtl/spi_lane_pkg.sv
package spi_lane_pkg;
  localparam int LANES  = 8;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    LW_1 = 2'd0,
    LW_2 = 2'd1,
    LW_4 = 2'd2,
    LW_8 = 2'd3
  } lane_w_e;

  localparam int OFS_CFG  = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_EN   = 'h10;
  localparam int OFS_TX0  = 'h14;
  localparam int OFS_TX3  = 'h20;
  localparam int OFS_RX   = 'h24;
  localparam int OFS_DIV  = 'h28;
  localparam int OFS_CTRL = 'h30;

  function automatic logic [3:0] lane_count(lane_w_e sel);
    return 4'd1 << sel;
  endfunction
endpackage

// File: rtl/spi_lane_regs.sv
module spi_lane_regs
  import spi_lane_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic                busy,
  input  logic                done,
  input  logic [WORD_W-1:0]   rx_word,
  output logic                cs_man,
  output logic                cs_set,
  output logic                idle_hi,
  output logic                cpol,
  output logic                cpha,
  output logic                en,
  output logic                rd_xfer,
  output lane_w_e             lane_sel,
  output logic [DIV_W-1:0]    half_div,
  output logic                start,
  output logic [WORD_W-1:0]   start_word,
  output logic [2:0]          start_nbytes
);
  logic              cfg_we, en_we, div_we, ctrl_we, tx_hit, rx_rd;
  logic              rx_valid_q, rx_valid_d;
  logic [ADDR_W-1:0] tx_ofs;
  logic [1:0]        tx_k;

  always_comb begin
    cfg_we  = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
    en_we   = bus_wr && (bus_addr == ADDR_W'(OFS_EN));
    div_we  = bus_wr && (bus_addr == ADDR_W'(OFS_DIV));
    ctrl_we = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    tx_hit  = bus_wr && (bus_addr >= ADDR_W'(OFS_TX0)) &&
              (bus_addr <= ADDR_W'(OFS_TX3)) && (bus_addr[1:0] == 2'b00);
    tx_ofs  = bus_addr - ADDR_W'(OFS_TX0);
    tx_k    = tx_ofs[3:2];
    start   = tx_hit && en && !busy;
    start_word   = bus_wdata;
    start_nbytes = (tx_k == 2'd0) ? 3'd4 : {1'b0, tx_k};
    rx_rd   = bus_rd && (bus_addr == ADDR_W'(OFS_RX));
    rx_valid_d = done ? 1'b1 : (rx_rd ? 1'b0 : rx_valid_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_man   <= 1'b0;
      cs_set   <= 1'b0;
      idle_hi  <= 1'b0;
      cpol     <= 1'b0;
      cpha     <= 1'b0;
      en       <= 1'b0;
      rd_xfer  <= 1'b0;
      lane_sel <= LW_1;
      half_div <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        cs_set  <= bus_wdata[0];
        cs_man  <= bus_wdata[1];
        idle_hi <= bus_wdata[16];
        cpol    <= bus_wdata[19];
        cpha    <= bus_wdata[20];
      end
      if (en_we)   en <= bus_wdata[0];
      if (ctrl_we) begin
        lane_sel <= lane_w_e'(bus_wdata[7:6]);
        rd_xfer  <= bus_wdata[23];
      end
      if (div_we)  half_div <= bus_wdata[DIV_W-1:0];
      rx_valid_q <= rx_valid_d;
    end
  end

  always_comb begin
    case (int'(bus_addr))
      OFS_CFG:  bus_rdata = {11'b0, cpha, cpol, 2'b0, idle_hi, 14'b0, cs_man, cs_set};
      OFS_STAT: bus_rdata = {28'b0, !rx_valid_q, rx_valid_q, !busy, !busy};
      OFS_EN:   bus_rdata = {31'b0, en};
      OFS_RX:   bus_rdata = rx_word;
      OFS_DIV:  bus_rdata = WORD_W'(half_div);
      OFS_CTRL: bus_rdata = {8'b0, rd_xfer, 15'b0, lane_sel, 6'b0};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_lane_clkgen.sv
module spi_lane_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic [DIV_W-1:0] half_div,
  output logic             mid_tick,
  output logic             end_tick,
  output logic             in_second
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sec_d, wrap;

  always_comb begin
    wrap     = busy && (cnt_q == half_div);
    mid_tick = wrap && !in_second;
    end_tick = wrap && in_second;
    cnt_d    = cnt_q;
    sec_d    = in_second;
    if (start) begin
      cnt_d = '0;
      sec_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      sec_d = !in_second;
    end else if (busy) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      in_second <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      in_second <= sec_d;
    end
  end
endmodule

// File: rtl/spi_lane_shifter.sv
module spi_lane_shifter
  import spi_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] start_word,
  input  logic [2:0]        start_nbytes,
  input  lane_w_e           lane_sel,
  input  logic              rd_xfer,
  input  logic              mid_tick,
  input  logic              end_tick,
  input  logic [LANES-1:0]  lane_in,
  output logic              busy,
  output logic              done,
  output logic [LANES-1:0]  lane_drive,
  output logic [WORD_W-1:0] rx_word
);
  logic              rd_q;
  lane_w_e           sel_q;
  logic [WORD_W-1:0] tx_q, tx_d, rx_d;
  logic [7:0]        acc_q, acc_d, in_bits;
  logic [5:0]        pos_q, pos_d, nbits_q;
  logic [3:0]        w;
  logic              busy_d;

  always_comb begin
    w = lane_count(sel_q);
    in_bits = '0;
    if (sel_q == LW_1) begin
      in_bits[0] = lane_in[1];
    end else begin
      for (int i = 0; i < LANES; i++)
        if (i < int'(w)) in_bits = in_bits | (8'(lane_in[i]) << (int'(w) - 1 - i));
    end
    for (int i = 0; i < LANES; i++)
      lane_drive[i] = (!rd_q && (i < int'(w))) ? tx_q[WORD_W-1-i] : 1'b1;
    done = busy && end_tick && (pos_q == nbits_q);
  end

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_word;
    acc_d  = acc_q;
    pos_d  = pos_q;
    busy_d = busy;
    if (start) begin
      tx_d   = {start_word[7:0], start_word[15:8], start_word[23:16], start_word[31:24]};
      rx_d   = '0;
      acc_d  = '0;
      pos_d  = '0;
      busy_d = 1'b1;
    end else if (mid_tick) begin
      acc_d = 8'((acc_q << w) | in_bits);
      pos_d = pos_q + 6'(w);
      if (pos_d[2:0] == 3'd0) rx_d = {acc_d, rx_word[WORD_W-1:8]};
    end else if (end_tick) begin
      tx_d = tx_q << w;
      if (done) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_q    <= 1'b0;
      sel_q   <= LW_1;
      tx_q    <= '0;
      rx_word <= '0;
      acc_q   <= '0;
      pos_q   <= '0;
      nbits_q <= '0;
    end else begin
      if (start) begin
        rd_q    <= rd_xfer;
        sel_q   <= lane_sel;
        nbits_q <= 6'({start_nbytes, 3'b000});
      end
      busy    <= busy_d;
      tx_q    <= tx_d;
      rx_word <= rx_d;
      acc_q   <= acc_d;
      pos_q   <= pos_d;
    end
  end
endmodule

// File: rtl/spi_lane_host.sv
module spi_lane_host
  import spi_lane_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              cs_n,
  output logic [7:0]        lane_out,
  input  logic [7:0]        lane_in
);
  logic cs_man, cs_set, idle_hi, cpol, cpha, en, rd_xfer;
  logic start, busy, done, mid_tick, end_tick, in_second;
  lane_w_e           lane_sel;
  logic [DIV_W-1:0]  half_div;
  logic [WORD_W-1:0] start_word, rx_word;
  logic [2:0]        start_nbytes;
  logic [LANES-1:0]  lane_drive;

  spi_lane_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .rx_word(rx_word),
    .cs_man(cs_man), .cs_set(cs_set), .idle_hi(idle_hi), .cpol(cpol),
    .cpha(cpha), .en(en), .rd_xfer(rd_xfer), .lane_sel(lane_sel),
    .half_div(half_div), .start(start), .start_word(start_word),
    .start_nbytes(start_nbytes)
  );

  spi_lane_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .half_div(half_div), .mid_tick(mid_tick), .end_tick(end_tick),
    .in_second(in_second)
  );

  spi_lane_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .start_word(start_word),
    .start_nbytes(start_nbytes), .lane_sel(lane_sel), .rd_xfer(rd_xfer),
    .mid_tick(mid_tick), .end_tick(end_tick), .lane_in(lane_in),
    .busy(busy), .done(done), .lane_drive(lane_drive), .rx_word(rx_word)
  );

  always_comb begin
    lane_out = busy ? lane_drive : {LANES{idle_hi}};
    sclk     = busy ? (cpol ^ (cpha ? !in_second : in_second)) : cpol;
    cs_n     = !(cs_man ? cs_set : busy);
  end
endmodule

// File: rtl/spi_lane_host_chk.sv
module spi_lane_host_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              en,
  input logic              busy,
  input logic              done,
  input logic              cs_n,
  input logic              sclk,
  input logic              cpol,
  input logic              idle_hi,
  input logic [7:0]        lane_out,
  input logic              cs_man,
  input logic              cs_set
);
  logic tx_wr;
  always_comb
    tx_wr = bus_wr && (bus_addr >= ADDR_W'('h14)) && (bus_addr <= ADDR_W'('h20)) &&
            (bus_addr[1:0] == 2'b00);

  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == cpol));

  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !en && !busy) |=> !busy);

  assert_done_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_idle_lanes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && idle_hi) |-> (lane_out == 8'hFF));

  assert_cs_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cs_man && cs_set) |=> !cs_n);
endmodule

bind spi_lane_host spi_lane_host_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .en(en),
  .busy(busy), .done(done), .cs_n(cs_n), .sclk(sclk), .cpol(cpol),
  .idle_hi(idle_hi), .lane_out(lane_out), .cs_man(cs_man), .cs_set(cs_set)
);

// File: tb/tb_spi_lane_host.sv
`timescale 1ns/1ps
module tb_spi_lane_host;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sclk, cs_n;
  logic [7:0]  lane_out, lane_in;

  bit   single, inv, armed, cpol_m, cpha_m, finished;
  int   tests, fails, cyc, last_edge, period, cs_rises;
  bit   sclk_p, cs_p;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign lane_in = single ? {6'b0, lane_out[0] ^ inv, 1'b0} : (lane_out ^ {8{inv}});

  spi_lane_host dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .cs_n(cs_n), .lane_out(lane_out), .lane_in(lane_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Monitor: pops one predicted lane value per sampling edge of sclk.
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n && !cs_p) cs_rises++;
      if (armed && sclk != sclk_p && sclk == (cpol_m ^ !cpha_m)) begin
        period    = cyc - last_edge;
        last_edge = cyc;
        if (exp_q.size() == 0) chk(1'b0, "R3 extra sampling edge", 32'(lane_out), 32'h0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(lane_out == e, "R4 lane value at edge", 32'(lane_out), 32'(e));
          chk(cs_n == 1'b0, "R8 cs low at edge", 32'(cs_n), 32'h0);
        end
      end
    end
    sclk_p = sclk;
    cs_p   = cs_n;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic set_cfg(input logic [31:0] v);
    wr(8'h00, v);
    cpol_m = v[19];
    cpha_m = v[20];
  endtask

  // Driver: predicts lane values and received word, then runs one transfer.
  task automatic xfer(input int k, input logic [31:0] word, input int sel, input bit rdm, input bit poke);
    int n, w;
    logic [31:0] exp_rx, s, r;
    n = (k == 0) ? 4 : k;
    w = 1 << sel;
    single = (sel == 0);
    exp_rx = '0;
    for (int j = 0; j < n; j++) begin
      logic [7:0] b, rb;
      b  = word[8*j +: 8];
      rb = rdm ? 8'hFF : (b ^ {8{inv}});
      exp_rx = exp_rx | (32'(rb) << (8 * (4 - n + j)));
      for (int sl = 0; sl < 8 / w; sl++) begin
        logic [7:0] v;
        v = 8'hFF;
        if (!rdm) for (int i = 0; i < w; i++) v[i] = b[7 - sl * w - i];
        exp_q.push_back(v);
      end
    end
    wr(8'h30, (32'(rdm) << 23) | (32'(sel) << 6));
    armed = 1'b1;
    wr(8'h14 + 8'(4 * k), word);
    if (poke) begin
      wr(8'h14, 32'hDEAD_BEEF);
      rd(8'h04, s);
      chk(s[1:0] == 2'b00, "R6 busy status", s, 32'h0);
    end
    for (int t = 0; t < 5000; t++) begin
      rd(8'h04, s);
      if (s[0]) break;
    end
    armed = 1'b0;
    chk(exp_q.size() == 0, "R3 edge count", 32'(exp_q.size()), 32'h0);
    exp_q.delete();
    chk(s[3:0] == 4'h7, "R6 status after done", s, 32'h7);
    rd(8'h24, r);
    chk(r == exp_rx, poke ? "R7 rx after ignored write" : "R5 rx word", r, exp_rx);
    rd(8'h04, s);
    chk(s[3:0] == 4'hB, "R6 status after rx read", s, 32'hB);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 32'(cyc), 32'h0);
    finish_run();
  end

  initial begin
    logic [31:0] s;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    single = 1; inv = 0; armed = 0; cpol_m = 0; cpha_m = 0;
    tests = 0; fails = 0; cyc = 0; last_edge = 0; period = 0; cs_rises = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h04, s);
    chk(s == 32'hB, "R1 reset status", s, 32'hB);
    chk({cs_n, sclk} == 2'b10, "R1 reset cs/sclk", {cs_n, sclk}, 2'b10);
    chk(lane_out == 8'h00, "R1 reset lanes", lane_out, 8'h00);

    set_cfg(32'h0001_0002);           // manual cs, idle lanes high
    wr(8'h28, 32'd1);
    chk(lane_out == 8'hFF, "R11 idle lanes high", lane_out, 8'hFF);
    chk(cs_n == 1'b1, "R8 manual cs deasserted", cs_n, 1'b1);

    // R2: enable clear, write must start nothing
    armed = 1'b1;
    wr(8'h14, 32'h1234_5678);
    repeat (20) @(negedge clk);
    armed = 1'b0;
    rd(8'h04, s);
    chk(s == 32'hB, "R2 no start while disabled", s, 32'hB);

    wr(8'h10, 32'h1);
    set_cfg(32'h0001_0003);
    chk(cs_n == 1'b0, "R8 manual cs asserted", cs_n, 1'b0);
    cs_rises = 0;
    xfer(1, 32'h5A5A_10A5, 0, 0, 0);  // R3 one byte via 0x18
    xfer(0, 32'h1234_5678, 0, 0, 0);  // R3 four bytes via 0x14
    chk(cs_rises == 0, "R8 cs held across transfers", 32'(cs_rises), 32'h0);

    inv = 1;
    xfer(3, 32'h00C3_B2A1, 2, 0, 0);  // R4 R5 quad, inverted loopback
    inv = 0;

    set_cfg(32'h0019_0003);           // R9 cpol=1 cpha=1
    chk(sclk == 1'b1, "R9 sclk idle at polarity", sclk, 1'b1);
    wr(8'h28, 32'd0);
    xfer(2, 32'hBEEF_8E71, 3, 0, 0);  // R12 octal
    xfer(0, 32'h0F1E_2D3C, 1, 0, 0);  // R12 dual
    xfer(2, 32'h0000_3355, 2, 1, 0);  // R11 read transfer drives ones

    set_cfg(32'h0001_0003);
    xfer(0, 32'hA1B2_C3D4, 0, 0, 1);  // R7 write while busy

    set_cfg(32'h0001_0000);           // auto chip-select
    chk(cs_n == 1'b1, "R8 auto cs idle", cs_n, 1'b1);
    wr(8'h28, 32'd3);
    xfer(1, 32'h0000_0096, 0, 0, 0);
    chk(cs_n == 1'b1, "R8 auto cs released", cs_n, 1'b1);
    chk(period == 8, "R10 sclk period", 32'(period), 32'd8);

    finish_run();
  end
endmodule